// File: doc/BRIEF.md
# Event Routing Channel Bank

This block is a bank of event routing channels. Each channel holds one 32-bit control word. The word picks one line out of a vector of producer event lines, which is grouped by producer. The channel can turn that line into one-clock pulses on chosen edges, widen it by one clock, and invert it. It can then merge the result with the result of its lower or upper neighbour. Each channel drives one registered output bit.

Software-style access uses one shared write/read port that is addressed by channel index. All producer inputs are taken as synchronous to `clk`. The asynchronous option is modelled as a path that skips the edge and widening stages. The output stays registered on that path.

Producer lines are grouped in blocks of eight. Source code `g` (1 ≤ g ≤ N_GRP) selects group `g-1`. Within that group, the 3-bit line code selects line `(g-1)*8 + line`.

Top module: `evt_route_bank`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, every control word reads 0, every `ch_out` bit is 0, and `rd_data` is 0.
- R2: A write with `wr_en` high stores `wr_data` into channel `wr_ch` at the clock edge. Only the defined bits are kept: line [2:0], source [14:8], edge mode [21:20], widen [25], invert [26], merge-lower [27], merge-upper [28] and bypass [30]. All other bits read as 0. `rd_data` returns the word of channel `rd_ch` as it stood before that same edge, one cycle later.
- R3: Source code 0, and any source code above N_GRP, gives a selected line of constant 0.
- R4: Edge mode 0 passes the selected line through unchanged.
- R5: Edge mode 1 gives a one-cycle pulse in the cycle in which the selected line is 1 and was 0 in the previous cycle.
- R6: Edge mode 2 gives a one-cycle pulse in the cycle in which the selected line is 0 and was 1 in the previous cycle.
- R7: Edge mode 3 gives a one-cycle pulse on every change of the selected line.
- R8: With widen set, the edge-stage value is ORed with its own value from the previous cycle, so a one-cycle pulse becomes two cycles wide.
- R9: With invert set, the value after widening is complemented.
- R10: With merge-lower set, channel i>0 ORs in the post-invert value of channel i-1.
- R11: With merge-upper set, channel i<N_CH-1 ANDs its value with the post-invert value of channel i+1. The merge-lower OR is applied first.
- R12: Channel 0 ignores merge-lower, and the last channel ignores merge-upper.
- R13: With bypass set, the channel skips the edge and widening stages: its value is the selected line, optionally inverted. The output is still registered.
- R14: Each `ch_out` bit is the merged channel value computed from the inputs and control words present before a clock edge, and registered at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control word write strobe |
| wr_ch | input | CH_W | Channel index written |
| wr_data | input | 32 | Control word to write |
| rd_ch | input | CH_W | Channel index read back |
| rd_data | output | 32 | Registered control word of `rd_ch` |
| src_evt | input | N_GRP*8 | Producer event lines, eight per group |
| ch_out | output | N_CH | Registered channel outputs |

## Verification
The bench builds the block with its defaults: four channels and eight producer groups. With four channels there are two interior channels, and these have both a lower and an upper neighbour, so merge-lower and merge-upper can be active on the same channel. Both end channels are also present, which brings the ignored end cases of R12 within reach. Eight groups leave source codes 9 to 127 unlisted, so R3 can be exercised, while the last group still tests the top of the line vector.

// File: rtl/evr_pkg.sv
package evr_pkg;
  localparam int WORD_W  = 32;
  localparam int LINE_W  = 3;
  localparam int SRC_W   = 7;
  localparam int LINES   = 1 << LINE_W;
  localparam logic [WORD_W-1:0] CTRL_MASK = 32'h5E30_7F07;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_ANY  = 2'd3
  } edge_mode_e;

  typedef struct packed {
    logic [LINE_W-1:0] line;
    logic [SRC_W-1:0]  src;
    edge_mode_e        mode;
    logic              widen;
    logic              invert;
    logic              merge_lo;
    logic              merge_hi;
    logic              bypass;
  } ch_cfg_t;

  function automatic ch_cfg_t decode_cfg(input logic [WORD_W-1:0] w);
    ch_cfg_t c;
    c.line     = w[2:0];
    c.src      = w[14:8];
    c.mode     = edge_mode_e'(w[21:20]);
    c.widen    = w[25];
    c.invert   = w[26];
    c.merge_lo = w[27];
    c.merge_hi = w[28];
    c.bypass   = w[30];
    return c;
  endfunction
endpackage

// File: rtl/evr_ctrl_regs.sv
module evr_ctrl_regs #(
  parameter int N_CH = 4,
  localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [CH_W-1:0]           wr_ch,
  input  logic [31:0]               wr_data,
  input  logic [CH_W-1:0]           rd_ch,
  output logic [31:0]               rd_data,
  output logic [N_CH-1:0][31:0]     ctrl
);
  import evr_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl    <= '0;
      rd_data <= '0;
    end else begin
      if (int'(rd_ch) < N_CH) rd_data <= ctrl[rd_ch];
      else                    rd_data <= '0;
      if (wr_en && int'(wr_ch) < N_CH) ctrl[wr_ch] <= wr_data & CTRL_MASK;
    end
  end

  // R1: the first cycle after reset shows a cleared read port
  a_r1_read_cleared: assert property (@(posedge clk) rst |=> rd_data == '0);
endmodule

// File: rtl/evr_src_mux.sv
module evr_src_mux #(
  parameter int N_GRP = 8,
  localparam int LINES = evr_pkg::LINES,
  localparam int SW    = N_GRP * LINES
) (
  input  logic [SW-1:0]              src_evt,
  input  logic [evr_pkg::SRC_W-1:0]  src,
  input  logic [evr_pkg::LINE_W-1:0] line,
  output logic                       sel
);
  always_comb begin
    sel = 1'b0;
    for (int g = 0; g < N_GRP; g++) begin
      if (int'(src) == g + 1) sel = src_evt[g*LINES + int'(line)];
    end
  end
endmodule

// File: rtl/evr_shaper.sv
module evr_shaper (
  input  logic                clk,
  input  logic                rst,
  input  logic                sel,
  input  evr_pkg::edge_mode_e mode,
  input  logic                widen,
  input  logic                invert,
  input  logic                bypass,
  output logic                val
);
  import evr_pkg::*;

  logic sel_q, pulse_q, pulse, wide;

  always_comb begin
    unique case (mode)
      EDGE_RISE: pulse = sel & ~sel_q;
      EDGE_FALL: pulse = ~sel & sel_q;
      EDGE_ANY:  pulse = sel ^ sel_q;
      default:   pulse = sel;
    endcase
  end

  assign wide = widen ? (pulse | pulse_q) : pulse;
  assign val  = (bypass ? sel : wide) ^ invert;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      sel_q   <= sel;
      pulse_q <= pulse;
    end
  end

  // R5: a rising-edge pulse never lasts two cycles
  a_r5_rise_single: assert property (@(posedge clk) disable iff (rst)
    (mode == EDGE_RISE && pulse) |=> !(mode == EDGE_RISE && pulse));
  // R6: a falling-edge pulse never lasts two cycles
  a_r6_fall_single: assert property (@(posedge clk) disable iff (rst)
    (mode == EDGE_FALL && pulse) |=> !(mode == EDGE_FALL && pulse));
  // R8: a pulse seen last cycle is still present after widening
  a_r8_widen_hold: assert property (@(posedge clk) disable iff (rst)
    (widen && $past(pulse)) |-> wide);
endmodule

// File: rtl/evt_route_bank.sv
module evt_route_bank #(
  parameter int N_CH  = 4,
  parameter int N_GRP = 8,
  localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int SW   = N_GRP * evr_pkg::LINES
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [CH_W-1:0] wr_ch,
  input  logic [31:0]     wr_data,
  input  logic [CH_W-1:0] rd_ch,
  output logic [31:0]     rd_data,
  input  logic [SW-1:0]   src_evt,
  output logic [N_CH-1:0] ch_out
);
  import evr_pkg::*;

  logic [N_CH-1:0][31:0] ctrl;
  ch_cfg_t               cfg [N_CH];
  logic [N_CH-1:0]       sel, v, or_in, and_kill, merged;

  evr_ctrl_regs #(.N_CH(N_CH)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ch(wr_ch), .wr_data(wr_data),
    .rd_ch(rd_ch), .rd_data(rd_data), .ctrl(ctrl)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    assign cfg[i] = decode_cfg(ctrl[i]);

    evr_src_mux #(.N_GRP(N_GRP)) u_mux (
      .src_evt(src_evt), .src(cfg[i].src), .line(cfg[i].line), .sel(sel[i])
    );

    evr_shaper u_shape (
      .clk(clk), .rst(rst), .sel(sel[i]), .mode(cfg[i].mode),
      .widen(cfg[i].widen), .invert(cfg[i].invert), .bypass(cfg[i].bypass),
      .val(v[i])
    );

    if (i > 0) begin : g_lo
      assign or_in[i] = cfg[i].merge_lo & v[i-1];
    end else begin : g_lo_none
      assign or_in[i] = 1'b0;
    end

    if (i < N_CH - 1) begin : g_hi
      assign and_kill[i] = cfg[i].merge_hi & ~v[i+1];
    end else begin : g_hi_none
      assign and_kill[i] = 1'b0;
    end

    assign merged[i] = (v[i] | or_in[i]) & ~and_kill[i];

    // R3: a missing or unlisted source never yields a set line
    a_r3_no_source: assert property (@(posedge clk) disable iff (rst)
      (cfg[i].src == '0 || int'(cfg[i].src) > N_GRP) |-> !sel[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) ch_out <= '0;
    else     ch_out <= merged;
  end

  // R1: outputs are cleared in the cycle after reset
  a_r1_out_cleared: assert property (@(posedge clk) rst |=> ch_out == '0);
endmodule

// File: tb/tb_evt_route_bank.sv
module tb_evt_route_bank;
  localparam int N_CH = 4;
  localparam int N_GRP = 8;
  localparam int LINES = 8;
  localparam int CH_W = 2;
  localparam int SW = N_GRP * LINES;
  localparam bit [31:0] MASK = 32'h5E30_7F07;

  logic clk = 1'b0;
  logic rst;
  logic wr_en;
  logic [CH_W-1:0] wr_ch, rd_ch;
  logic [31:0] wr_data, rd_data;
  logic [SW-1:0] src_evt;
  logic [N_CH-1:0] ch_out;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string req = "R1";

  bit [31:0] mctrl [N_CH];
  bit msel [N_CH];
  bit mpul [N_CH];
  bit [N_CH-1:0] exp_out;
  bit [31:0] exp_rd;

  evt_route_bank #(.N_CH(N_CH), .N_GRP(N_GRP)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ch(wr_ch), .wr_data(wr_data),
    .rd_ch(rd_ch), .rd_data(rd_data), .src_evt(src_evt), .ch_out(ch_out)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit [31:0] mk(input int line, input int src, input int mode,
                                   input bit wid, input bit inv, input bit mlo,
                                   input bit mhi, input bit byp);
    return (32'(line) & 32'h7) | ((32'(src) & 32'h7F) << 8) | ((32'(mode) & 32'h3) << 20)
         | (32'(wid) << 25) | (32'(inv) << 26) | (32'(mlo) << 27) | (32'(mhi) << 28)
         | (32'(byp) << 30);
  endfunction

  function automatic bit [SW-1:0] rnd_src();
    return {$urandom, $urandom};
  endfunction

  // one clock: drive at negedge, predict, then compare at next negedge
  task automatic step(input bit w, input int ch, input bit [31:0] d, input bit [SW-1:0] s);
    bit v [N_CH];
    wr_en = w; wr_ch = CH_W'(ch); wr_data = d; rd_ch = CH_W'(ch); src_evt = s;
    for (int i = 0; i < N_CH; i++) begin
      int src = int'(mctrl[i][14:8]);
      int line = int'(mctrl[i][2:0]);
      int mode = int'(mctrl[i][21:20]);
      bit sl, p, wv;
      sl = (src >= 1 && src <= N_GRP) ? s[(src-1)*LINES + line] : 1'b0;
      case (mode)
        1: p = sl && !msel[i];
        2: p = !sl && msel[i];
        3: p = sl != msel[i];
        default: p = sl;
      endcase
      wv = mctrl[i][25] ? (p || mpul[i]) : p;
      v[i] = (mctrl[i][30] ? sl : wv) ^ mctrl[i][26];
      msel[i] = sl;
      mpul[i] = p;
    end
    for (int i = 0; i < N_CH; i++) begin
      bit c = v[i];
      if (i > 0 && mctrl[i][27]) c = c | v[i-1];
      if (i < N_CH - 1 && mctrl[i][28]) c = c & v[i+1];
      exp_out[i] = c;
    end
    exp_rd = mctrl[ch];
    if (w) mctrl[ch] = d & MASK;
    @(posedge clk);
    @(negedge clk);
    check({req, " out"}, 32'(ch_out), 32'(exp_out));
    check("R2 readback", rd_data, exp_rd);
  endtask

  task automatic cfg4(input bit [31:0] a, input bit [31:0] b, input bit [31:0] c, input bit [31:0] d);
    step(1, 0, a, rnd_src());
    step(1, 1, b, rnd_src());
    step(1, 2, c, rnd_src());
    step(1, 3, d, rnd_src());
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) step(0, k % N_CH, 0, rnd_src());
  endtask

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1; wr_en = 0; wr_ch = 0; wr_data = 0; rd_ch = 0; src_evt = '0;
    for (int i = 0; i < N_CH; i++) begin mctrl[i] = 0; msel[i] = 0; mpul[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1: reset state
    check("R1 out", 32'(ch_out), 32'h0);
    check("R1 read", rd_data, 32'h0);

    // R2: masked storage and readback
    req = "R2";
    step(1, 1, 32'hFFFF_FFFF, '0);
    step(0, 1, 0, '0);
    check("R2 mask", rd_data, MASK);
    step(1, 1, 0, '0);

    // R3: source 0 and unlisted sources give 0
    req = "R3";
    cfg4(mk(5, 0, 0, 0, 0, 0, 0, 0), mk(2, 9, 0, 0, 0, 0, 0, 0),
         mk(0, 100, 0, 0, 0, 0, 0, 0), mk(7, 127, 3, 0, 0, 0, 0, 0));
    for (int k = 0; k < 4; k++) step(0, k, 0, '1);
    check("R3 all-ones", 32'(ch_out), 32'h0);
    run(10);

    req = "R4";
    cfg4(mk(3, 1, 0, 0, 0, 0, 0, 0), mk(0, 4, 0, 0, 0, 0, 0, 0),
         mk(6, 6, 0, 0, 0, 0, 0, 0), mk(7, 8, 0, 0, 0, 0, 0, 0));
    run(30);

    req = "R5";
    cfg4(mk(1, 1, 1, 0, 0, 0, 0, 0), mk(2, 3, 1, 0, 0, 0, 0, 0),
         mk(4, 5, 1, 0, 0, 0, 0, 0), mk(7, 8, 1, 0, 0, 0, 0, 0));
    run(40);

    req = "R6";
    cfg4(mk(1, 2, 2, 0, 0, 0, 0, 0), mk(2, 3, 2, 0, 0, 0, 0, 0),
         mk(4, 7, 2, 0, 0, 0, 0, 0), mk(0, 8, 2, 0, 0, 0, 0, 0));
    run(40);

    req = "R7";
    cfg4(mk(0, 1, 3, 0, 0, 0, 0, 0), mk(5, 2, 3, 0, 0, 0, 0, 0),
         mk(3, 6, 3, 0, 0, 0, 0, 0), mk(6, 8, 3, 0, 0, 0, 0, 0));
    run(40);

    req = "R8";
    cfg4(mk(0, 1, 1, 1, 0, 0, 0, 0), mk(5, 2, 0, 1, 0, 0, 0, 0),
         mk(3, 6, 2, 1, 0, 0, 0, 0), mk(6, 8, 3, 1, 0, 0, 0, 0));
    run(40);
    // directed: single-cycle high on group 1 line 0 must give a 2-cycle pulse on channel 0
    step(0, 0, 0, '0); step(0, 0, 0, '0);
    step(0, 0, 0, 64'h1);
    check("R8 first", 32'(ch_out[0]), 32'h1);
    step(0, 0, 0, '0);
    check("R8 held", 32'(ch_out[0]), 32'h1);
    step(0, 0, 0, '0);
    check("R8 end", 32'(ch_out[0]), 32'h0);

    req = "R9";
    cfg4(mk(0, 1, 0, 0, 1, 0, 0, 0), mk(5, 2, 1, 0, 1, 0, 0, 0),
         mk(3, 0, 0, 0, 1, 0, 0, 0), mk(6, 8, 3, 1, 1, 0, 0, 0));
    run(40);

    req = "R10";
    cfg4(mk(0, 1, 0, 0, 0, 0, 0, 0), mk(5, 2, 1, 0, 0, 1, 0, 0),
         mk(3, 6, 0, 0, 0, 1, 0, 0), mk(6, 0, 0, 0, 0, 1, 0, 0));
    run(40);

    req = "R11";
    cfg4(mk(0, 1, 0, 0, 0, 0, 1, 0), mk(5, 2, 0, 0, 0, 1, 1, 0),
         mk(3, 6, 2, 0, 0, 0, 1, 0), mk(6, 8, 0, 0, 0, 0, 0, 0));
    run(40);

    req = "R12";
    cfg4(mk(0, 0, 0, 0, 0, 1, 0, 0), mk(0, 0, 0, 0, 1, 0, 0, 0),
         mk(0, 0, 0, 0, 0, 0, 0, 0), mk(0, 0, 0, 0, 1, 0, 1, 0));
    run(4);
    // channel 0 ignores merge-lower, channel 3 ignores merge-upper
    check("R12 ends", 32'(ch_out), 32'b1010);
    cfg4(mk(1, 1, 0, 0, 0, 1, 0, 0), mk(0, 0, 0, 0, 1, 0, 0, 0),
         mk(2, 2, 0, 0, 0, 0, 0, 0), mk(3, 3, 1, 0, 0, 0, 1, 0));
    run(30);

    req = "R13";
    cfg4(mk(0, 1, 1, 1, 0, 0, 0, 1), mk(5, 2, 2, 0, 1, 0, 0, 1),
         mk(3, 6, 3, 1, 1, 0, 0, 1), mk(6, 8, 0, 1, 0, 1, 0, 1));
    run(40);

    req = "R14";
    for (int r = 0; r < 30; r++) begin
      cfg4($urandom, $urandom, $urandom, $urandom);
      run(25);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule